// File: doc/BRIEF.md
# Indirect Bus Command Bridge

This block lets a 64-bit register port drive single transactions on an internal bus with 32-bit addresses and byte lanes. Software first stores a 32-bit word in a data register, then writes one command word that carries the direction, the byte count and the bus address. The bridge raises a request on its master port and holds it until the slave answers. When the answer arrives, the bridge records a done flag in a status register, together with the read data for a read.

Software polls the status register for completion. Reading the status register returns its value and clears it in the same access. Only one transaction can be in flight at a time. A command that arrives while the bus is busy is dropped. A command whose byte count is out of range is also dropped.

Top module: `ind_cmd_bridge`

## Requirements
- R1: The register is selected by `reg_addr[4:3]`: 0 is command, 1 is reset, 2 is status and 3 is data. The other address bits are ignored.
- R2: In a command word, bit 48 set means a read and clear means a write. Bits [59:56] are the byte count and bits [31:0] are the bus address. After an accepted command, `bus_we`, `bus_len` and `bus_addr` reflect these fields. All other bits of the command word are ignored.
- R3: A command with a byte count above 8 starts no transaction and leaves the status register unchanged.
- R4: After a read that completes without error, the status register holds the done flag in bit 11 and `bus_rdata[63:32]` in bits [57:26]. Byte lane 0 is `bus_rdata[63:56]` and lands in the most significant data byte.
- R5: After a read that completes with `bus_err` high, the status register holds the done flag in bit 11 and all ones in bits [57:26].
- R6: A write transaction drives the data register on `bus_wdata[63:32]`, with its most significant byte in lane 0, and zeros in the remaining lanes. When the write completes, the status register holds only the done flag, whatever `bus_err` says.
- R7: A write to the data register stores `reg_wdata[63:32]`. A read of the data register returns the stored word in bits [63:32], with zeros below.
- R8: A status read returns the current value and clears the register to zero afterwards. If a bus completion arrives in the same cycle, the completion's value wins.
- R9: Reads of the command and reset registers return zero. Writes to the status and reset registers change nothing.
- R10: `bus_req` stays high with stable `bus_we`, `bus_addr`, `bus_len` and `bus_wdata` until a cycle with `bus_ack`. It drops in the next cycle. A command written while `bus_req` is high is ignored.
- R11: The done flag becomes set only in the cycle after a bus acknowledge.
- R12: After reset, `bus_req` is low and both the status and data registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 64 | Register write value |
| reg_rdata | output | 64 | Register read value, valid in the cycle of the read |
| bus_req | output | 1 | Transaction request, held until acknowledged |
| bus_we | output | 1 | 1 = write transaction |
| bus_addr | output | 32 | Transaction address |
| bus_len | output | 4 | Transaction byte count |
| bus_wdata | output | 8*LANES | Write data, lane 0 in the top byte |
| bus_ack | input | 1 | Slave response this cycle |
| bus_err | input | 1 | Response carries an error |
| bus_rdata | input | 8*LANES | Read data, lane 0 in the top byte |

## Verification
The bound checker checks the bus handshake on every cycle:
- request hold and field stability until the acknowledge;
- the request dropping after the acknowledge;
- the done flag rising only after an acknowledge;
- zero reads from the command and reset registers and the zero lower half of data reads;
- the clear after a status read;
- the refusal of oversized commands.

The packing of read data, the all-ones pattern after an error, big-endian write lanes, the status left untouched by a dropped command, and the command ignored while busy depend on values spread over whole sequences. These show up only through the bench's directed and random scenarios, which compare against values the bench computes itself.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef enum logic [1:0] {
    SEL_CMD   = 2'd0,
    SEL_RST   = 2'd1,
    SEL_STAT  = 2'd2,
    SEL_DATA  = 2'd3
  } reg_sel_e;

  localparam int WORD_W     = 64;
  localparam int XFER_W     = 32;
  localparam int LEN_W      = 4;
  localparam int CMD_RD_BIT = 48;
  localparam int CMD_LEN_LO = 56;
  localparam int DONE_BIT   = 11;
  localparam int RFIELD_LO  = 26;
  localparam int MAX_BYTES  = 8;
endpackage

// File: rtl/bridge_regs.sv
module bridge_regs
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic [WORD_W-1:0]   acc_wdata,
  input  logic [WORD_W-1:0]   status_word,
  output logic [WORD_W-1:0]   acc_rdata,
  output logic [XFER_W-1:0]   data_word,
  output logic                cmd_fire,
  output logic                stat_rd
);
  reg_sel_e          sel;
  logic              data_en;
  logic [XFER_W-1:0] data_d, data_q;

  assign sel      = reg_sel_e'(acc_addr[4:3]);
  assign cmd_fire = acc_valid &&  acc_write && (sel == SEL_CMD);
  assign stat_rd  = acc_valid && !acc_write && (sel == SEL_STAT);
  assign data_en  = acc_valid &&  acc_write && (sel == SEL_DATA);
  assign data_d   = acc_wdata[WORD_W-1 -: XFER_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  always_comb begin
    acc_rdata = '0;
    if (acc_valid && !acc_write) begin
      case (sel)
        SEL_STAT: acc_rdata = status_word;
        SEL_DATA: acc_rdata = {data_q, {(WORD_W-XFER_W){1'b0}}};
        default:  acc_rdata = '0;
      endcase
    end
  end

  assign data_word = data_q;
endmodule

// File: rtl/bridge_engine.sv
module bridge_engine
  import bridge_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_fire,
  input  logic [WORD_W-1:0]    cmd_word,
  input  logic                 stat_rd,
  input  logic [XFER_W-1:0]    data_word,
  input  logic                 bus_ack,
  input  logic                 bus_err,
  input  logic [8*LANES-1:0]   bus_rdata,
  output logic                 bus_req,
  output logic                 bus_we,
  output logic [XFER_W-1:0]    bus_addr,
  output logic [LEN_W-1:0]     bus_len,
  output logic [8*LANES-1:0]   bus_wdata,
  output logic [WORD_W-1:0]    status_word
);
  localparam int BUS_W    = 8 * LANES;
  localparam int SRC_B    = XFER_W / 8;

  logic              busy_d, busy_q;
  logic              we_d, we_q;
  logic [XFER_W-1:0] addr_d, addr_q;
  logic [LEN_W-1:0]  len_d, len_q;
  logic [BUS_W-1:0]  wd_lanes, wd_d, wd_q;
  logic              done_d, done_q;
  logic [XFER_W-1:0] fld_d, fld_q;
  logic              accept, finish, load_en, stat_en;
  logic [LEN_W-1:0]  cmd_len;

  assign cmd_len = cmd_word[CMD_LEN_LO +: LEN_W];
  assign accept  = cmd_fire && !busy_q && (int'(cmd_len) <= MAX_BYTES);
  assign finish  = busy_q && bus_ack;
  assign load_en = accept;
  assign stat_en = finish || stat_rd;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i < SRC_B) begin : g_src
      assign wd_lanes[BUS_W-1-8*i -: 8] = data_word[XFER_W-1-8*i -: 8];
    end else begin : g_pad
      assign wd_lanes[BUS_W-1-8*i -: 8] = 8'h00;
    end
  end

  always_comb begin
    busy_d = busy_q;
    if (accept)      busy_d = 1'b1;
    else if (finish) busy_d = 1'b0;
    we_d   = !cmd_word[CMD_RD_BIT];
    addr_d = cmd_word[XFER_W-1:0];
    len_d  = cmd_len;
    wd_d   = wd_lanes;
  end

  always_comb begin
    done_d = 1'b0;
    fld_d  = '0;
    if (finish) begin
      done_d = 1'b1;
      if (we_q)         fld_d = '0;
      else if (bus_err) fld_d = '1;
      else              fld_d = bus_rdata[BUS_W-1 -: XFER_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      len_q  <= '0;
      wd_q   <= '0;
    end else if (load_en) begin
      we_q   <= we_d;
      addr_q <= addr_d;
      len_q  <= len_d;
      wd_q   <= wd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      fld_q  <= '0;
    end else if (stat_en) begin
      done_q <= done_d;
      fld_q  <= fld_d;
    end
  end

  always_comb begin
    status_word = '0;
    status_word[DONE_BIT] = done_q;
    status_word[RFIELD_LO +: XFER_W] = fld_q;
  end

  assign bus_req   = busy_q;
  assign bus_we    = we_q;
  assign bus_addr  = addr_q;
  assign bus_len   = len_q;
  assign bus_wdata = wd_q;
endmodule

// File: rtl/ind_cmd_bridge.sv
module ind_cmd_bridge
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LANES  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_valid,
  input  logic                reg_write,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [63:0]         reg_wdata,
  output logic [63:0]         reg_rdata,
  output logic                bus_req,
  output logic                bus_we,
  output logic [31:0]         bus_addr,
  output logic [3:0]          bus_len,
  output logic [8*LANES-1:0]  bus_wdata,
  input  logic                bus_ack,
  input  logic                bus_err,
  input  logic [8*LANES-1:0]  bus_rdata
);
  logic [WORD_W-1:0] status_word;
  logic [XFER_W-1:0] data_word;
  logic              cmd_fire;
  logic              stat_rd;

  bridge_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (reg_valid),
    .acc_write   (reg_write),
    .acc_addr    (reg_addr),
    .acc_wdata   (reg_wdata),
    .status_word (status_word),
    .acc_rdata   (reg_rdata),
    .data_word   (data_word),
    .cmd_fire    (cmd_fire),
    .stat_rd     (stat_rd)
  );

  bridge_engine #(.LANES(LANES)) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_fire    (cmd_fire),
    .cmd_word    (reg_wdata),
    .stat_rd     (stat_rd),
    .data_word   (data_word),
    .bus_ack     (bus_ack),
    .bus_err     (bus_err),
    .bus_rdata   (bus_rdata),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_len     (bus_len),
    .bus_wdata   (bus_wdata),
    .status_word (status_word)
  );
endmodule

// File: rtl/ind_cmd_bridge_chk.sv
module ind_cmd_bridge_chk #(
  parameter int ADDR_W = 16,
  parameter int LANES  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_valid,
  input logic               reg_write,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [63:0]        reg_wdata,
  input logic [63:0]        reg_rdata,
  input logic               bus_req,
  input logic               bus_we,
  input logic [31:0]        bus_addr,
  input logic [3:0]         bus_len,
  input logic [8*LANES-1:0] bus_wdata,
  input logic               bus_ack,
  input logic [63:0]        status_word
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr)
                            && $stable(bus_len) && $stable(bus_wdata));

  assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack |=> !bus_req);

  assert_done_after_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_word[11]) |-> $past(bus_req && bus_ack));

  assert_zero_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && !reg_write && !reg_addr[4] |-> reg_rdata == 64'd0);

  assert_data_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && !reg_write && reg_addr[4:3] == 2'd3 |-> reg_rdata[31:0] == 32'd0);

  assert_stat_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && !reg_write && reg_addr[4:3] == 2'd2 && !(bus_req && bus_ack)
    |=> status_word == 64'd0);

  assert_oversize_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && reg_write && reg_addr[4:3] == 2'd0 && reg_wdata[59:56] > 4'd8
    && !bus_req |=> !bus_req);
endmodule

bind ind_cmd_bridge ind_cmd_bridge_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_valid   (reg_valid),
  .reg_write   (reg_write),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .bus_req     (bus_req),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_len     (bus_len),
  .bus_wdata   (bus_wdata),
  .bus_ack     (bus_ack),
  .status_word (status_word)
);

// File: tb/ind_cmd_bridge_bench.sv
`timescale 1ns/1ps
module ind_cmd_bridge_bench;
  localparam int ADDR_W = 16;
  localparam int LANES  = 8;

  logic               clk;
  logic               rst_n;
  logic               reg_valid, reg_write;
  logic [ADDR_W-1:0]  reg_addr;
  logic [63:0]        reg_wdata, reg_rdata;
  logic               bus_req, bus_we;
  logic [31:0]        bus_addr;
  logic [3:0]         bus_len;
  logic [63:0]        bus_wdata, bus_rdata;
  logic               bus_ack, bus_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [63:0] model_stat;
  logic [31:0] model_data;

  ind_cmd_bridge #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ind_cmd_bridge (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_len(bus_len),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] addr_of(input logic [1:0] sel);
    logic [ADDR_W-1:0] a;
    a = ADDR_W'($urandom);
    a[4:3] = sel;
    a[2:0] = 3'b000;
    return a;
  endfunction

  function automatic logic [63:0] exp_read_stat(input logic err, input logic [63:0] rd);
    logic [63:0] s;
    s = 64'd0;
    s[11] = 1'b1;
    s[57:26] = err ? 32'hFFFF_FFFF : rd[63:32];
    return s;
  endfunction

  function automatic logic [63:0] make_cmd(input logic rd, input logic [3:0] len,
                                           input logic [31:0] a);
    logic [63:0] c;
    c = {$urandom, $urandom};
    c[48] = rd;
    c[59:56] = len;
    c[31:0] = a;
    return c;
  endfunction

  task automatic reg_wr(input logic [1:0] sel, input logic [63:0] v);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = addr_of(sel); reg_wdata = v;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0; reg_wdata = {$urandom, $urandom};
  endtask

  task automatic reg_rd(input logic [1:0] sel, output logic [63:0] v);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = addr_of(sel);
    #1 v = reg_rdata;
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  task automatic read_stat(input string req);
    logic [63:0] v;
    reg_rd(2'd2, v);
    check(req, v, model_stat);
    model_stat = 64'd0;
  endtask

  task automatic respond(input int lat, input logic err, input logic [63:0] rd);
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      check("R10 request held", {63'd0, bus_req}, 64'd1);
    end
    bus_ack = 1'b1; bus_err = err; bus_rdata = rd;
    @(negedge clk);
    bus_ack = 1'b0; bus_err = 1'b0; bus_rdata = {$urandom, $urandom};
    check("R10 request released", {63'd0, bus_req}, 64'd0);
  endtask

  task automatic run_cmd(input logic rd, input logic [3:0] len, input logic [31:0] a,
                         input int lat, input logic err, input logic [63:0] rdv);
    reg_wr(2'd0, make_cmd(rd, len, a));
    if (len > 4'd8) begin
      check("R3 oversize no request", {63'd0, bus_req}, 64'd0);
      @(negedge clk);
      check("R3 oversize no request later", {63'd0, bus_req}, 64'd0);
    end else begin
      check("R2 request", {63'd0, bus_req}, 64'd1);
      check("R2 direction", {63'd0, bus_we}, {63'd0, !rd});
      check("R2 address", {32'd0, bus_addr}, {32'd0, a});
      check("R2 length", {60'd0, bus_len}, {60'd0, len});
      if (!rd) check("R6 write lanes", bus_wdata, {model_data, 32'd0});
      respond(lat, err, rdv);
      if (rd) model_stat = exp_read_stat(err, rdv);
      else begin model_stat = 64'd0; model_stat[11] = 1'b1; end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [31:0] seed;
    seed = $urandom(32'h5EED_0042);
    rst_n = 1'b0; reg_valid = 1'b0; reg_write = 1'b0; reg_addr = '0; reg_wdata = '0;
    bus_ack = 1'b0; bus_err = 1'b0; bus_rdata = '0;
    model_stat = 64'd0; model_data = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    check("R12 no request", {63'd0, bus_req}, 64'd0);
    reg_rd(2'd2, v); check("R12 status zero", v, 64'd0);
    reg_rd(2'd3, v); check("R12 data zero", v, 64'd0);

    // R7 data register capture and readback
    reg_wr(2'd3, 64'hA1B2_C3D4_1122_3344);
    model_data = 32'hA1B2_C3D4;
    reg_rd(2'd3, v); check("R7 data readback", v, 64'hA1B2_C3D4_0000_0000);

    // R9 command and reset registers read zero
    reg_rd(2'd0, v); check("R9 command reads zero", v, 64'd0);
    reg_rd(2'd1, v); check("R9 reset reads zero", v, 64'd0);

    // R4 read success packing, R8 read then clear
    run_cmd(1'b1, 4'd4, 32'hD001_0060, 0, 1'b0, 64'h1234_5678_9ABC_DEF0);
    read_stat("R4 read status");
    read_stat("R8 status cleared");

    // R5 read error all ones
    run_cmd(1'b1, 4'd1, 32'hE000_0010, 2, 1'b1, 64'h0);
    read_stat("R5 error status");

    // R6 write ignores error, R9 writes to status and reset do nothing
    run_cmd(1'b0, 4'd8, 32'hF000_1000, 1, 1'b1, 64'h0);
    reg_wr(2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
    reg_wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R9 no request after reset write", {63'd0, bus_req}, 64'd0);
    read_stat("R6 write status done only");

    // R3 oversize command leaves pending status intact
    run_cmd(1'b1, 4'd2, 32'h0000_0400, 0, 1'b0, 64'hCAFE_F00D_0000_0000);
    run_cmd(1'b1, 4'd9, 32'h0000_0500, 0, 1'b0, 64'h0);
    read_stat("R3 status unchanged");

    // R10 command while busy ignored
    reg_wr(2'd0, make_cmd(1'b1, 4'd4, 32'h1111_0000));
    reg_wr(2'd0, make_cmd(1'b0, 4'd2, 32'h2222_0000));
    check("R10 busy address kept", {32'd0, bus_addr}, 64'h1111_0000);
    check("R10 busy direction kept", {63'd0, bus_we}, 64'd0);
    respond(0, 1'b0, 64'h0102_0304_0506_0708);
    check("R10 no second request", {63'd0, bus_req}, 64'd0);
    model_stat = exp_read_stat(1'b0, 64'h0102_0304_0506_0708);
    read_stat("R10 first command result");

    // R1 R11 random mix with varied upper address bits
    for (int it = 0; it < 60; it++) begin
      logic rd;
      logic [3:0] len;
      if ($urandom_range(0, 3) == 0) begin
        logic [63:0] dv;
        dv = {$urandom, $urandom};
        reg_wr(2'd3, dv);
        model_data = dv[63:32];
      end
      rd  = 1'($urandom);
      len = 4'($urandom_range(0, 11));
      run_cmd(rd, len, $urandom, $urandom_range(0, 3), 1'($urandom),
              {$urandom, $urandom});
      if ($urandom_range(0, 1) == 0) read_stat("R1 R11 random status");
    end
    read_stat("R11 final status");
    reg_rd(2'd3, v); check("R1 data via random address", v, {model_data, 32'd0});

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule